// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block takes interrupt-vector requests from a delivery network and turns them into a pending vector trap for the processor. Each request is a level together with a small interrupt number. While no vector is pending, a high level is captured. The block sets its busy flag, fills three 64-bit data words that the processor later reads, loads the trap index with the vector-interrupt code, pulses a wake strobe that releases a halted processor, and holds a hard-interrupt request. While the busy flag is set, no further request is accepted. The pending vector is released when the requester lowers its level or when software asserts the clear input.

The control is a two-state machine. IDLE means nothing is pending and BUSY means a vector is latched. The ACCEPT transition goes from IDLE to BUSY and is taken when the level is high. The RELEASE transition goes from BUSY to IDLE and is taken when the level is low or the software clear is high. The HOLD transition keeps BUSY when the level stays high and no clear arrives; incoming numbers are ignored in that case. The WAIT transition keeps IDLE while the level is low. Registered outputs change on the clock edge that takes the transition, so they are visible one cycle after the inputs are presented.

Top module: `ivec_latch`

## Requirements
- R1: After reset the status word, all three data words, the trap index, the hard-interrupt request and the wake strobe are all zero.
- R2: In IDLE with the level high, the next cycle shows status bit 5 (the busy flag) set and the hard-interrupt request high.
- R3: On acceptance, data word 0 becomes 0x7C0 OR the interrupt number, which puts the number in bits 5:0 and all ones in bits 10:6 with every other bit zero. Data words 1 and 2 become zero.
- R4: On acceptance the trap index becomes 0x060, and it keeps that value after release.
- R5: The wake strobe is high for exactly the one cycle that follows an acceptance and is low at all other times.
- R6: While busy with the level high and no clear, a changed interrupt number has no effect: the data words stay unchanged and busy stays set.
- R7: While busy, a low level clears the busy flag and the hard-interrupt request in the next cycle, and the data words keep their latched values.
- R8: While busy, the software clear releases the latch in the next cycle even if the level is high. If the level is still high in the cycle after that, a new acceptance captures the current number.
- R9: Status bits other than bit 5 always read zero, and the hard-interrupt request always equals the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_level | input | 1 | Request level from the vector source |
| req_num | input | 6 | Interrupt number carried with the request |
| sw_clear | input | 1 | Software release of a pending vector |
| status | output | 8 | Status word; bit 5 is the busy flag |
| data0 | output | 64 | Data word 0: fixed marker field and interrupt number |
| data1 | output | 64 | Data word 1, zero on capture |
| data2 | output | 64 | Data word 2, zero on capture |
| trap_idx | output | 9 | Trap index presented to dispatch |
| hard_req | output | 1 | Hard-interrupt request to the processor |
| wake | output | 1 | One-cycle strobe that releases a halted processor |

## Verification
The properties assume that the request number is stable during the cycle in which it is sampled. They also assume that all inputs are known once reset is released. The bench drives every input on the falling clock edge and holds it for a full cycle, so both assumptions hold. The bench sweeps all 64 interrupt numbers through the ACCEPT, HOLD and RELEASE paths. During HOLD it presents a different number, so a faulty capture would change data word 0. A separate pass exercises the software clear and the re-acceptance that follows it.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ivec_state_t;

    localparam int unsigned NUM_W    = 6;
    localparam int unsigned DATA_W   = 64;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned BUSY_BIT = 5;
    localparam int unsigned TRAP_W   = 9;
    localparam int unsigned MARK_W   = 5;
    localparam logic [TRAP_W-1:0] VEC_TRAP = 9'h060;
endpackage

// File: rtl/ivec_fsm.sv
module ivec_fsm
    import ivec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_level,
    input  logic sw_clear,
    output logic busy,
    output logic accept
);
    ivec_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transition and output decode
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_level) begin
                    state_d = ST_BUSY;   // ACCEPT
                    accept  = 1'b1;
                end
            end
            ST_BUSY: begin
                if (sw_clear || !req_level)
                    state_d = ST_IDLE;   // RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_BUSY);
endmodule

// File: rtl/ivec_data.sv
module ivec_data
    import ivec_pkg::*;
#(
    parameter int unsigned N_WORDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [NUM_W-1:0]     num,
    output logic [DATA_W-1:0]    word [N_WORDS]
);
    localparam int unsigned PAD_W = DATA_W - MARK_W - NUM_W;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] load_val;
        if (w == 0) begin : g_first
            assign load_val = {{PAD_W{1'b0}}, {MARK_W{1'b1}}, num};
        end else begin : g_rest
            assign load_val = '0;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)      word[w] <= '0;
            else if (accept) word[w] <= load_val;
        end
    end
endmodule

// File: rtl/ivec_out.sv
module ivec_out
    import ivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    output logic [STAT_W-1:0] status,
    output logic [TRAP_W-1:0] trap_idx,
    output logic              wake
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_idx <= '0;
            wake     <= 1'b0;
        end else begin
            wake <= accept;
            if (accept) trap_idx <= VEC_TRAP;
        end
    end

    always_comb begin
        status           = '0;
        status[BUSY_BIT] = busy;
    end
endmodule

// File: rtl/ivec_latch.sv
module ivec_latch
    import ivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_level,
    input  logic [5:0]        req_num,
    input  logic              sw_clear,
    output logic [7:0]        status,
    output logic [63:0]       data0,
    output logic [63:0]       data1,
    output logic [63:0]       data2,
    output logic [8:0]        trap_idx,
    output logic              hard_req,
    output logic              wake
);
    logic busy, accept;
    logic [DATA_W-1:0] words [3];

    ivec_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_level(req_level),
        .sw_clear(sw_clear), .busy(busy), .accept(accept)
    );

    ivec_data #(.N_WORDS(3)) u_data (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .num(req_num), .word(words)
    );

    ivec_out u_out (
        .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
        .status(status), .trap_idx(trap_idx), .wake(wake)
    );

    assign data0    = words[0];
    assign data1    = words[1];
    assign data2    = words[2];
    assign hard_req = busy;
endmodule

// File: rtl/ivec_latch_chk.sv
module ivec_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_level,
    input logic [5:0]  req_num,
    input logic        sw_clear,
    input logic [7:0]  status,
    input logic [63:0] data0,
    input logic [63:0] data1,
    input logic [63:0] data2,
    input logic [8:0]  trap_idx,
    input logic        hard_req,
    input logic        wake
);
    // R2
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[5] && req_level) |=> (status[5] && hard_req));

    // R3
    accept_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[5] && req_level) |=>
        (data0 == (64'h7C0 | {58'd0, $past(req_num)}) && data1 == 64'd0 && data2 == 64'd0));

    // R4
    accept_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[5] && req_level) |=> (trap_idx == 9'h060));

    // R5
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R5
    wake_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[5] && req_level) |=> wake);

    // R6
    hold_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && req_level && !sw_clear) |=> ($stable(data0) && status[5] && !wake));

    // R7
    lower_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !req_level) |=> (!status[5] && !hard_req && $stable(data0)));

    // R8
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && sw_clear) |=> !status[5]);

    // R9
    status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & 8'hDF) == 8'h00) && (hard_req == status[5]));
endmodule

bind ivec_latch ivec_latch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_level(req_level), .req_num(req_num),
    .sw_clear(sw_clear), .status(status), .data0(data0), .data1(data1),
    .data2(data2), .trap_idx(trap_idx), .hard_req(hard_req), .wake(wake)
);

// File: tb/tb_ivec_latch.sv
`timescale 1ns/1ps
module tb_ivec_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_level = 1'b0;
    logic [5:0]  req_num = '0;
    logic        sw_clear = 1'b0;
    logic [7:0]  status;
    logic [63:0] data0, data1, data2;
    logic [8:0]  trap_idx;
    logic        hard_req, wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ivec_latch dut (
        .clk(clk), .rst_n(rst_n), .req_level(req_level), .req_num(req_num),
        .sw_clear(sw_clear), .status(status), .data0(data0), .data1(data1),
        .data2(data2), .trap_idx(trap_idx), .hard_req(hard_req), .wake(wake)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] word0(input int n);
        return 64'h7C0 | 64'(n);
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", 64'(status), 64'h0);
        chk("R1 data0", data0, 64'h0);
        chk("R1 data1", data1, 64'h0);
        chk("R1 data2", data2, 64'h0);
        chk("R1 trap", 64'(trap_idx), 64'h0);
        chk("R1 hard", 64'(hard_req), 64'h0);
        chk("R1 wake", 64'(wake), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < 64; n++) begin
            req_level = 1'b1;
            req_num   = 6'(n);
            @(negedge clk);
            chk("R2 busy", 64'(status), 64'h20);
            chk("R2 hard", 64'(hard_req), 64'h1);
            chk("R3 data0", data0, word0(n));
            chk("R3 data1", data1, 64'h0);
            chk("R3 data2", data2, 64'h0);
            chk("R4 trap", 64'(trap_idx), 64'h060);
            chk("R5 wake", 64'(wake), 64'h1);
            req_num = 6'(n) ^ 6'h2A;
            @(negedge clk);
            chk("R6 data0", data0, word0(n));
            chk("R6 busy", 64'(status), 64'h20);
            chk("R5 wake low", 64'(wake), 64'h0);
            req_level = 1'b0;
            @(negedge clk);
            chk("R7 status", 64'(status), 64'h0);
            chk("R7 hard", 64'(hard_req), 64'h0);
            chk("R7 data0", data0, word0(n));
            chk("R4 trap held", 64'(trap_idx), 64'h060);
            chk("R9 hard eq busy", 64'(hard_req), 64'(status[5]));
        end

        for (int k = 0; k < 8; k++) begin
            int a = (k * 9) % 64;
            int b = (k * 23 + 5) % 64;
            req_level = 1'b1;
            req_num   = 6'(a);
            @(negedge clk);
            chk("R8 first", data0, word0(a));
            sw_clear = 1'b1;
            req_num  = 6'(b);
            @(negedge clk);
            chk("R8 cleared", 64'(status), 64'h0);
            chk("R8 hard low", 64'(hard_req), 64'h0);
            chk("R8 kept", data0, word0(a));
            sw_clear = 1'b0;
            @(negedge clk);
            chk("R8 reaccept", data0, word0(b));
            chk("R8 busy", 64'(status), 64'h20);
            chk("R8 wake", 64'(wake), 64'h1);
            req_level = 1'b0;
            @(negedge clk);
            chk("R9 status", 64'(status), 64'h0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule